// File: doc/BRIEF.md
# Segmented Address Formation Unit

This unit sits between address generation and the memory path. It turns a 64-bit effective address into a final address by adding the contents of one of sixteen segment base registers. The kind of access decides which register is used. A load or store uses the register numbered by the address's top nibble. A code fetch always uses the last register, unless the address already lies in the top nibble region 0xF; that region is reserved for system code and is never segmented. An I/O access is never segmented.

The segment registers are written and read through a single port that serves the move-to and move-from segment operations. The register number comes either from an immediate field (direct form) or from the low nibble of a general register (indirect form). The address path is combinational. Register writes land on the clock edge. The low 12 bits of every segment register are hardwired to zero, so a segment base always falls on a 4 KiB boundary.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset every segment register reads zero, and every access produces a final address equal to its effective address.
- R2: For a data access (`acc_type_i` = 0), the final address is the effective address plus segment register number `ea_i[63:60]`.
- R3: For a code access (`acc_type_i` = 1), the final address is the effective address plus segment register 15. When `ea_i[63:60]` is 0xF, the effective address passes through unchanged.
- R4: For an I/O access (`acc_type_i` = 2, with 3 treated the same way), the effective address passes through unchanged whatever the segment registers hold.
- R5: The addition wraps modulo 2^64, and a carry out of bit 63 is discarded.
- R6: Bits 11:0 of each segment register are zero after any write and read back as zero. Bits 11:0 of the final address always equal bits 11:0 of the effective address.
- R7: With `seg_ind_i` = 0, writes and reads address the register numbered by `seg_idx_imm_i`.
- R8: With `seg_ind_i` = 1, writes and reads address the register numbered by `seg_idx_reg_i`.
- R9: A write becomes visible, on both the read port and the address path, starting in the cycle after the write edge. During the write cycle both still show the old value.
- R10: A write changes only the register it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ea_i | input | 64 | Effective address |
| acc_type_i | input | 2 | Access kind: 0 data, 1 code, 2 or 3 I/O |
| sa_o | output | 64 | Final segmented address |
| seg_we_i | input | 1 | Segment register write strobe |
| seg_ind_i | input | 1 | Selects the indirect register number |
| seg_idx_imm_i | input | 4 | Register number from the immediate field |
| seg_idx_reg_i | input | 4 | Register number from a general register |
| seg_wdata_i | input | 64 | Write value |
| seg_rdata_o | output | 64 | Current value of the addressed register |

## Verification
The bench aims at the code-fetch bypass boundary. It uses 0xF top-nibble addresses with a nonzero register 15, and addresses just below that region. A design that ignored the bypass would shift system code, and one that bypassed too broadly would leave user code unsegmented. It also sets up sums that carry out of bit 63 to catch a widened or saturating adder. It writes all-ones values to catch low bits that are stored instead of being cleared. It gives the direct and indirect register numbers different values, which exposes a swapped number mux. It checks the read port and the address path during the write cycle itself, which exposes a write-through bypass that would make a new base visible one cycle early.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
   typedef enum logic [1:0] {
      ACC_DATA   = 2'd0,
      ACC_CODE   = 2'd1,
      ACC_IO     = 2'd2,
      ACC_IO_ALT = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/seg_sel.sv
module seg_sel
   import seg_addr_pkg::*;
#(
   parameter int IDX_W    = 4,
   parameter int CODE_SEG = 15
) (
   input  logic [IDX_W-1:0] top_i,
   input  acc_kind_e        kind_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             bypass_o
);
   localparam logic [IDX_W-1:0] CODE_IDX = IDX_W'(CODE_SEG);

   always_comb begin
      idx_o    = top_i;
      bypass_o = 1'b0;
      unique case (kind_i)
         ACC_DATA: begin
            idx_o    = top_i;
            bypass_o = 1'b0;
         end
         ACC_CODE: begin
            idx_o    = CODE_IDX;
            bypass_o = &top_i;
         end
         default: begin
            idx_o    = top_i;
            bypass_o = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile #(
   parameter int ADDR_W  = 64,
   parameter int SEG_CNT = 16,
   parameter int ZLSB    = 12,
   parameter int IDX_W   = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [IDX_W-1:0]                 widx_i,
   input  logic [ADDR_W-1:0]                wdata_i,
   output logic [SEG_CNT-1:0][ADDR_W-1:0]   seg_o
);
   logic [ADDR_W-1:0] wval;

   generate
      if (ZLSB > 0) begin : g_masked
         assign wval = {wdata_i[ADDR_W-1:ZLSB], {ZLSB{1'b0}}};
      end else begin : g_full
         assign wval = wdata_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_o <= '0;
      end else if (we_i) begin
         for (int i = 0; i < SEG_CNT; i++) begin
            if (widx_i == IDX_W'(i)) seg_o[i] <= wval;
         end
      end
   end
endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
   parameter int ADDR_W = 64,
   parameter int ZLSB   = 12
) (
   input  logic [ADDR_W-1:0] ea_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              bypass_i,
   output logic [ADDR_W-1:0] sa_o
);
   generate
      if (ZLSB > 0) begin : g_split
         logic [ADDR_W-ZLSB-1:0] hi_base;
         assign hi_base          = bypass_i ? '0 : base_i[ADDR_W-1:ZLSB];
         assign sa_o[ZLSB-1:0]   = ea_i[ZLSB-1:0];
         assign sa_o[ADDR_W-1:ZLSB] = ea_i[ADDR_W-1:ZLSB] + hi_base;
      end else begin : g_whole
         assign sa_o = ea_i + (bypass_i ? '0 : base_i);
      end
   endgenerate
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
   import seg_addr_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int SEG_CNT  = 16,
   parameter int ZLSB     = 12,
   parameter int CODE_SEG = SEG_CNT - 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             ea_i,
   input  logic [1:0]                    acc_type_i,
   output logic [ADDR_W-1:0]             sa_o,
   input  logic                          seg_we_i,
   input  logic                          seg_ind_i,
   input  logic [$clog2(SEG_CNT)-1:0]    seg_idx_imm_i,
   input  logic [$clog2(SEG_CNT)-1:0]    seg_idx_reg_i,
   input  logic [ADDR_W-1:0]             seg_wdata_i,
   output logic [ADDR_W-1:0]             seg_rdata_o
);
   localparam int IDX_W = $clog2(SEG_CNT);

   generate
      if ((1 << IDX_W) != SEG_CNT) begin : g_bad_cnt
         $error("SEG_CNT must be a power of two");
      end
      if (ZLSB >= ADDR_W) begin : g_bad_zlsb
         $error("ZLSB must be below ADDR_W");
      end
      if (CODE_SEG >= SEG_CNT) begin : g_bad_code
         $error("CODE_SEG out of range");
      end
   endgenerate

   logic [SEG_CNT-1:0][ADDR_W-1:0] segs;
   logic [IDX_W-1:0]               op_idx;
   logic [IDX_W-1:0]               acc_idx;
   logic                           bypass;

   assign op_idx = seg_ind_i ? seg_idx_reg_i : seg_idx_imm_i;

   seg_regfile #(
      .ADDR_W (ADDR_W),
      .SEG_CNT(SEG_CNT),
      .ZLSB   (ZLSB),
      .IDX_W  (IDX_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (seg_we_i),
      .widx_i (op_idx),
      .wdata_i(seg_wdata_i),
      .seg_o  (segs)
   );

   seg_sel #(
      .IDX_W   (IDX_W),
      .CODE_SEG(CODE_SEG)
   ) u_sel (
      .top_i   (ea_i[ADDR_W-1 -: IDX_W]),
      .kind_i  (acc_kind_e'(acc_type_i)),
      .idx_o   (acc_idx),
      .bypass_o(bypass)
   );

   seg_adder #(
      .ADDR_W(ADDR_W),
      .ZLSB  (ZLSB)
   ) u_add (
      .ea_i    (ea_i),
      .base_i  (segs[acc_idx]),
      .bypass_i(bypass),
      .sa_o    (sa_o)
   );

   assign seg_rdata_o = segs[op_idx];
endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
   parameter int ADDR_W  = 64,
   parameter int SEG_CNT = 16,
   parameter int ZLSB    = 12
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          ea_i,
   input logic [1:0]                 acc_type_i,
   input logic [ADDR_W-1:0]          sa_o,
   input logic                       seg_we_i,
   input logic                       seg_ind_i,
   input logic [$clog2(SEG_CNT)-1:0] seg_idx_imm_i,
   input logic [$clog2(SEG_CNT)-1:0] seg_idx_reg_i,
   input logic [ADDR_W-1:0]          seg_wdata_i,
   input logic [ADDR_W-1:0]          seg_rdata_o
);
   localparam int IDX_W = $clog2(SEG_CNT);
   logic [IDX_W-1:0] sel_now;
   assign sel_now = seg_ind_i ? seg_idx_reg_i : seg_idx_imm_i;

   // R4
   io_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_type_i[1] |-> sa_o == ea_i);

   // R3
   code_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type_i == 2'd1 && &ea_i[ADDR_W-1 -: IDX_W]) |-> sa_o == ea_i);

   // R6
   low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sa_o[ZLSB-1:0] == ea_i[ZLSB-1:0]);

   // R6
   rdata_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_rdata_o[ZLSB-1:0] == '0);

   // R9
   write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_we_i && !seg_ind_i && !$past(seg_we_i)) |=>
         ((seg_ind_i ? seg_idx_reg_i : seg_idx_imm_i) == $past(sel_now)) |->
            seg_rdata_o[ADDR_W-1:ZLSB] == $past(seg_wdata_i[ADDR_W-1:ZLSB]));
endmodule

bind seg_addr_unit seg_addr_unit_chk #(
   .ADDR_W (ADDR_W),
   .SEG_CNT(SEG_CNT),
   .ZLSB   (ZLSB)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ea_i         (ea_i),
   .acc_type_i   (acc_type_i),
   .sa_o         (sa_o),
   .seg_we_i     (seg_we_i),
   .seg_ind_i    (seg_ind_i),
   .seg_idx_imm_i(seg_idx_imm_i),
   .seg_idx_reg_i(seg_idx_reg_i),
   .seg_wdata_i  (seg_wdata_i),
   .seg_rdata_o  (seg_rdata_o)
);

// File: tb/seg_addr_unit_tb_top.sv
module seg_addr_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] ea_i = '0;
   logic [1:0]  acc_type_i = '0;
   logic [63:0] sa_o;
   logic        seg_we_i = 1'b0;
   logic        seg_ind_i = 1'b0;
   logic [3:0]  seg_idx_imm_i = '0;
   logic [3:0]  seg_idx_reg_i = '0;
   logic [63:0] seg_wdata_i = '0;
   logic [63:0] seg_rdata_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [63:0] model [16];

   always #2 clk = ~clk;

   seg_addr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .ea_i(ea_i), .acc_type_i(acc_type_i),
      .sa_o(sa_o), .seg_we_i(seg_we_i), .seg_ind_i(seg_ind_i),
      .seg_idx_imm_i(seg_idx_imm_i), .seg_idx_reg_i(seg_idx_reg_i),
      .seg_wdata_i(seg_wdata_i), .seg_rdata_o(seg_rdata_o)
   );

   function automatic logic [63:0] exp_sa(input logic [1:0] t, input logic [63:0] ea);
      case (t)
         2'd0: return ea + model[ea[63:60]];
         2'd1: return (ea[63:60] == 4'hF) ? ea : ea + model[15];
         default: return ea;
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input bit ind, input logic [3:0] idx, input logic [63:0] val);
      @(negedge clk);
      seg_we_i = 1'b1;
      seg_ind_i = ind;
      if (ind) begin
         seg_idx_reg_i = idx;
         seg_idx_imm_i = ~idx;
      end else begin
         seg_idx_imm_i = idx;
         seg_idx_reg_i = ~idx;
      end
      seg_wdata_i = val;
      @(negedge clk);
      seg_we_i = 1'b0;
      model[idx] = {val[63:12], 12'h000};
   endtask

   task automatic do_read(input string req, input bit ind, input logic [3:0] idx);
      seg_ind_i = ind;
      if (ind) begin
         seg_idx_reg_i = idx;
         seg_idx_imm_i = ~idx;
      end else begin
         seg_idx_imm_i = idx;
         seg_idx_reg_i = ~idx;
      end
      #1;
      chk(req, seg_rdata_o, model[idx]);
   endtask

   task automatic do_acc(input string req, input logic [1:0] t, input logic [63:0] ea);
      acc_type_i = t;
      ea_i = ea;
      #1;
      chk(req, sa_o, exp_sa(t, ea));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 16; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int i = 0; i < 16; i++) do_read("R1", 1'b0, 4'(i));
      do_acc("R1", 2'd0, 64'h7123_4567_89AB_CDEF);
      do_acc("R1", 2'd1, 64'h0000_0000_0000_1000);

      // R7 / R6: direct write with all-ones low bits
      do_write(1'b0, 4'd7, 64'hFFFF_FFFF_FFFF_FFFF);
      do_read("R6", 1'b0, 4'd7);
      do_read("R7", 1'b1, 4'd7);
      // R8: indirect write
      do_write(1'b1, 4'd3, 64'h0000_0001_0000_0ABC);
      do_read("R8", 1'b1, 4'd3);
      do_read("R10", 1'b0, 4'd12);
      do_read("R10", 1'b0, 4'd7);

      // R2: data uses top nibble
      do_acc("R2", 2'd0, 64'h3000_0000_0000_0010);
      // R5: wrap through segment 7
      do_acc("R5", 2'd0, 64'h7FFF_FFFF_FFFF_F123);

      // R3: code boundary
      do_write(1'b0, 4'd15, 64'h0000_0000_0040_0000);
      do_acc("R3", 2'd1, 64'hF000_0000_0000_0100);
      do_acc("R3", 2'd1, 64'hEFFF_FFFF_FFFF_F100);
      do_acc("R3", 2'd1, 64'h3000_0000_0000_0000);
      do_acc("R2", 2'd0, 64'hF000_0000_0000_0100);

      // R4: IO passes through
      do_acc("R4", 2'd2, 64'h7000_0000_00DC_4000);
      do_acc("R4", 2'd3, 64'hF000_0000_0000_0008);

      // R9: during write cycle the old value is still seen
      @(negedge clk);
      seg_we_i = 1'b1; seg_ind_i = 1'b0; seg_idx_imm_i = 4'd3; seg_idx_reg_i = 4'd0;
      seg_wdata_i = 64'h0000_0000_0000_5000;
      acc_type_i = 2'd0; ea_i = 64'h3000_0000_0000_0004;
      #1;
      chk("R9", seg_rdata_o, model[3]);
      chk("R9", sa_o, exp_sa(2'd0, 64'h3000_0000_0000_0004));
      @(negedge clk);
      seg_we_i = 1'b0;
      model[3] = 64'h0000_0000_0000_5000;
      #1;
      chk("R9", seg_rdata_o, model[3]);
      chk("R9", sa_o, 64'h3000_0000_0000_5004);

      // random mix
      for (int n = 0; n < 400; n++) begin
         int unsigned op = $urandom_range(0, 2);
         logic [63:0] v = {$urandom, $urandom};
         logic [3:0]  ix = 4'($urandom_range(0, 15));
         if (op == 0) begin
            do_write(1'($urandom_range(0, 1)), ix, v);
            do_read("R10", 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
         end else if (op == 1) begin
            do_read("R8", 1'($urandom_range(0, 1)), ix);
         end else begin
            do_acc("R2", 2'($urandom_range(0, 3)), v);
         end
      end

      // R1: reset clears again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) model[i] = '0;
      do_read("R1", 1'b0, 4'd15);
      do_acc("R1", 2'd1, 64'h1234_0000_0000_0000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule